// File: doc/BRIEF.md
# Two-Level Latched Interrupt Aggregator

This block gathers interrupt sources from a low-speed peripheral bus into a single level toward an upstream interrupt controller. Seventeen serial interrupt lines and a small set of bus error events are latched into a first-stage status register. A mask and a global enable bit gate that register, and the result reduces to one summary signal.

The summary appears as one bit of a second-stage raw input register. A second-stage status register latches raw input AND its own mask, and the output level is high while that status is nonzero. Both status registers are sticky. Software clears them by writing ones. Every register is reached through a 32-bit port addressed by byte offset. Reads return data on the clock edge after the request.

Top module: `irq_cascade_agg`

## Requirements
- R1: The control register (0x30), first-stage mask (0x34), second-stage mask (0x54) and polarity register (0x58) store any 32-bit value written to them and return it on read. Read data appears on `bus_rdata` one clock after a read request.
- R2: While serial line n is high, first-stage status bit (31 − n) is set. While error event k is high, status bit (2 + k) is set. A low level never clears a bit.
- R3: Writing the first-stage status register (0x38) or the second-stage status register (0x50) clears each bit that is written as 1. Bits written as 0 keep their value.
- R4: The first-stage summary is 1 only when control bit 31 is 1 and (first-stage status AND first-stage mask) is nonzero.
- R5: Bit 11 (0x800) of the raw input register (0x5C) follows the first-stage summary, both rising and falling. All other raw input bits read 0.
- R6: Every cycle, the second-stage status register ORs in (raw input AND second-stage mask). Its bits stay set until software clears them, even after the raw input falls.
- R7: `irq_out` is high one clock after the second-stage status is nonzero, and low one clock after it is zero.
- R8: The polarity value has no effect on `irq_out`. Writes to the raw input register are ignored.
- R9: Reads of any offset not listed in R1 to R8 return 0xFFFFFFFF. The error-address offset 0x40 reads 0. Writes to 0x40 and to unlisted offsets are ignored.
- R10: Synchronous reset clears every register, `bus_rdata` and `irq_out` to 0.
- R11: When a status bit is latched and cleared by software in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request, one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, registered |
| ser_irq | input | NUM_SER (17) | Serial interrupt lines, active high |
| err_evt | input | ERR_N (6) | Bus error event pulses, active high |
| irq_out | output | 1 | Interrupt level toward the upstream controller |

## Verification
The bench builds the block with its default parameters: 32-bit data, an 8-bit offset, 17 serial lines and six error events. Line 0 and line 16 therefore reach both ends of the serial field, bits 31 and 15. Error event 0 reaches bit 2. With the full offset space decoded, the bench can probe neighbouring unmapped offsets such as 0x44 to confirm the all-ones read and the ignored writes.

// File: rtl/irq_cascade_pkg.sv
`timescale 1ns/1ps
package irq_cascade_pkg;
  // Byte offsets of the register map
  localparam int unsigned OFF_HC_CTRL  = 32'h30;
  localparam int unsigned OFF_HC_MASK  = 32'h34;
  localparam int unsigned OFF_HC_STAT  = 32'h38;
  localparam int unsigned OFF_HC_EADDR = 32'h40;
  localparam int unsigned OFF_MS_STAT  = 32'h50;
  localparam int unsigned OFF_MS_MASK  = 32'h54;
  localparam int unsigned OFF_MS_POL   = 32'h58;
  localparam int unsigned OFF_MS_RAW   = 32'h5C;
  // Bit positions that neighbouring logic decodes
  localparam int unsigned EN_BIT  = 31;
  localparam int unsigned SUM_BIT = 11;
endpackage

// File: rtl/irq_hc_stage.sv
`timescale 1ns/1ps
// First stage: sticky status from serial lines and error events, mask, control.
module irq_hc_stage #(
  parameter int DW      = 32,
  parameter int NUM_SER = 17,
  parameter int ERR_N   = 6,
  parameter int ERR_LSB = 2,
  parameter int EN_BIT  = 31
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SER-1:0] ser_irq,
  input  logic [ERR_N-1:0]   err_evt,
  input  logic               ctrl_we,
  input  logic               mask_we,
  input  logic               stat_we,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      ctrl_q,
  output logic [DW-1:0]      mask_q,
  output logic [DW-1:0]      stat_q,
  output logic               summary
);
  logic [DW-1:0] set_v;
  logic [DW-1:0] clr_v;

  always_comb begin
    set_v = '0;
    for (int n = 0; n < NUM_SER; n++) set_v[DW-1-n] = ser_irq[n];
    for (int k = 0; k < ERR_N; k++) set_v[ERR_LSB+k] = err_evt[k];
  end

  assign clr_v = stat_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= wdata;
      if (mask_we) mask_q <= wdata;
      // latch-set wins over a software clear in the same cycle
      stat_q <= (stat_q & ~clr_v) | set_v;
    end
  end

  assign summary = ctrl_q[EN_BIT] & (|(stat_q & mask_q));
endmodule

// File: rtl/irq_ms_stage.sv
`timescale 1ns/1ps
// Second stage: raw input from the first-stage summary, sticky status, level out.
module irq_ms_stage #(
  parameter int DW      = 32,
  parameter int SUM_BIT = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          summary,
  input  logic          mask_we,
  input  logic          pol_we,
  input  logic          stat_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] raw,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] pol_q,
  output logic [DW-1:0] stat_q,
  output logic          irq_q
);
  logic [DW-1:0] clr_v;

  always_comb begin
    raw          = '0;
    raw[SUM_BIT] = summary;
  end

  assign clr_v = stat_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      pol_q  <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= wdata;
      if (pol_we)  pol_q  <= wdata;
      stat_q <= (stat_q & ~clr_v) | (raw & mask_q);
      irq_q  <= |stat_q;
    end
  end
endmodule

// File: rtl/irq_reg_rdmux.sv
`timescale 1ns/1ps
// Read-data selection by byte offset; unmapped offsets read all ones.
module irq_reg_rdmux
  import irq_cascade_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     hc_ctrl,
  input  logic [DW-1:0]     hc_mask,
  input  logic [DW-1:0]     hc_stat,
  input  logic [DW-1:0]     ms_stat,
  input  logic [DW-1:0]     ms_mask,
  input  logic [DW-1:0]     ms_pol,
  input  logic [DW-1:0]     ms_raw,
  output logic [DW-1:0]     rdata
);
  localparam logic [ADDR_W-1:0] A_HC_CTRL  = ADDR_W'(OFF_HC_CTRL);
  localparam logic [ADDR_W-1:0] A_HC_MASK  = ADDR_W'(OFF_HC_MASK);
  localparam logic [ADDR_W-1:0] A_HC_STAT  = ADDR_W'(OFF_HC_STAT);
  localparam logic [ADDR_W-1:0] A_HC_EADDR = ADDR_W'(OFF_HC_EADDR);
  localparam logic [ADDR_W-1:0] A_MS_STAT  = ADDR_W'(OFF_MS_STAT);
  localparam logic [ADDR_W-1:0] A_MS_MASK  = ADDR_W'(OFF_MS_MASK);
  localparam logic [ADDR_W-1:0] A_MS_POL   = ADDR_W'(OFF_MS_POL);
  localparam logic [ADDR_W-1:0] A_MS_RAW   = ADDR_W'(OFF_MS_RAW);

  always_comb begin
    case (addr)
      A_HC_CTRL:  rdata = hc_ctrl;
      A_HC_MASK:  rdata = hc_mask;
      A_HC_STAT:  rdata = hc_stat;
      A_HC_EADDR: rdata = '0;
      A_MS_STAT:  rdata = ms_stat;
      A_MS_MASK:  rdata = ms_mask;
      A_MS_POL:   rdata = ms_pol;
      A_MS_RAW:   rdata = ms_raw;
      default:    rdata = '1;
    endcase
  end
endmodule

// File: rtl/irq_cascade_agg.sv
`timescale 1ns/1ps
module irq_cascade_agg
  import irq_cascade_pkg::*;
#(
  parameter int DW      = 32,
  parameter int ADDR_W  = 8,
  parameter int NUM_SER = 17,
  parameter int ERR_N   = 6,
  parameter int ERR_LSB = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_req,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [NUM_SER-1:0] ser_irq,
  input  logic [ERR_N-1:0]   err_evt,
  output logic               irq_out
);
  localparam logic [ADDR_W-1:0] A_HC_CTRL = ADDR_W'(OFF_HC_CTRL);
  localparam logic [ADDR_W-1:0] A_HC_MASK = ADDR_W'(OFF_HC_MASK);
  localparam logic [ADDR_W-1:0] A_HC_STAT = ADDR_W'(OFF_HC_STAT);
  localparam logic [ADDR_W-1:0] A_MS_STAT = ADDR_W'(OFF_MS_STAT);
  localparam logic [ADDR_W-1:0] A_MS_MASK = ADDR_W'(OFF_MS_MASK);
  localparam logic [ADDR_W-1:0] A_MS_POL  = ADDR_W'(OFF_MS_POL);

  logic          wr_go;
  logic          rd_go;
  logic [DW-1:0] hc_ctrl, hc_mask, hc_stat;
  logic [DW-1:0] ms_raw, ms_mask, ms_pol, ms_stat;
  logic [DW-1:0] rd_mux;
  logic          hc_sum;

  assign wr_go = bus_req & bus_wr;
  assign rd_go = bus_req & ~bus_wr;

  irq_hc_stage #(
    .DW(DW), .NUM_SER(NUM_SER), .ERR_N(ERR_N), .ERR_LSB(ERR_LSB), .EN_BIT(EN_BIT)
  ) u_hc (
    .clk(clk), .rst(rst), .ser_irq(ser_irq), .err_evt(err_evt),
    .ctrl_we(wr_go && bus_addr == A_HC_CTRL),
    .mask_we(wr_go && bus_addr == A_HC_MASK),
    .stat_we(wr_go && bus_addr == A_HC_STAT),
    .wdata(bus_wdata),
    .ctrl_q(hc_ctrl), .mask_q(hc_mask), .stat_q(hc_stat), .summary(hc_sum)
  );

  irq_ms_stage #(.DW(DW), .SUM_BIT(SUM_BIT)) u_ms (
    .clk(clk), .rst(rst), .summary(hc_sum),
    .mask_we(wr_go && bus_addr == A_MS_MASK),
    .pol_we(wr_go && bus_addr == A_MS_POL),
    .stat_we(wr_go && bus_addr == A_MS_STAT),
    .wdata(bus_wdata),
    .raw(ms_raw), .mask_q(ms_mask), .pol_q(ms_pol), .stat_q(ms_stat), .irq_q(irq_out)
  );

  irq_reg_rdmux #(.DW(DW), .ADDR_W(ADDR_W)) u_rd (
    .addr(bus_addr), .hc_ctrl(hc_ctrl), .hc_mask(hc_mask), .hc_stat(hc_stat),
    .ms_stat(ms_stat), .ms_mask(ms_mask), .ms_pol(ms_pol), .ms_raw(ms_raw),
    .rdata(rd_mux)
  );

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_go) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_cascade_chk.sv
`timescale 1ns/1ps
module irq_cascade_chk #(
  parameter int DW      = 32,
  parameter int NUM_SER = 17
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SER-1:0] ser_irq,
  input logic [DW-1:0]      hc_ctrl,
  input logic [DW-1:0]      hc_mask,
  input logic [DW-1:0]      hc_stat,
  input logic [DW-1:0]      ms_raw,
  input logic [DW-1:0]      ms_stat,
  input logic               wr_go,
  input logic [7:0]         bus_addr,
  input logic [DW-1:0]      bus_wdata,
  input logic               irq_out
);
  // R2: a high serial line 0 is latched into bit 31
  a_r2_line0_latch: assert property (@(posedge clk) disable iff (rst)
    ser_irq[0] |=> hc_stat[DW-1]);

  // R4: without the enable bit the summary never reaches the raw input
  a_r4_enable_gate: assert property (@(posedge clk) disable iff (rst)
    !hc_ctrl[31] |-> !ms_raw[11]);

  // R5: raw input tracks status AND mask under the enable
  a_r5_raw_follows: assert property (@(posedge clk) disable iff (rst)
    ms_raw[11] == (hc_ctrl[31] && ((hc_stat & hc_mask) != '0)));

  // R5: only the summary bit of the raw input can be set
  a_r5_raw_single: assert property (@(posedge clk) disable iff (rst)
    (ms_raw & ~32'h0000_0800) == '0);

  // R6: a latched second-stage bit stays unless software clears it
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (ms_stat[11] && !(wr_go && bus_addr == 8'h50 && bus_wdata[11])) |=> ms_stat[11]);

  // R7: output level follows nonzero second-stage status one clock later
  a_r7_level: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == ($past(ms_stat) != '0)));

  // R10: reset clears the second stage and the output
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (ms_stat == '0 && !irq_out && hc_stat == '0));
endmodule

bind irq_cascade_agg irq_cascade_chk #(.DW(DW), .NUM_SER(NUM_SER)) u_chk (
  .clk(clk), .rst(rst), .ser_irq(ser_irq), .hc_ctrl(hc_ctrl), .hc_mask(hc_mask),
  .hc_stat(hc_stat), .ms_raw(ms_raw), .ms_stat(ms_stat), .wr_go(wr_go),
  .bus_addr(8'(bus_addr)), .bus_wdata(bus_wdata), .irq_out(irq_out)
);

// File: tb/irq_cascade_agg_tb_top.sv
`timescale 1ns/1ps
module irq_cascade_agg_tb_top;
  localparam int DW = 32, AW = 8, NS = 17, NE = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_req = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NS-1:0] ser_irq = '0;
  logic [NE-1:0] err_evt = '0;
  logic          irq_out;

  int checks = 0, errors = 0;
  logic [DW-1:0] rv;

  always #4 clk = ~clk; // 125 MHz

  irq_cascade_agg #(.DW(DW), .ADDR_W(AW), .NUM_SER(NS), .ERR_N(NE)) dut_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ser_irq(ser_irq),
    .err_evt(err_evt), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_req = 1'b0;
  endtask

  // vector: {is_read, addr, data, expected, requirement number}
  localparam int NV = 16;
  localparam logic [80:0] VEC [NV] = '{
    {1'b1, 8'h30, 32'h0,        32'h0,        8'd10}, // R10 control after reset
    {1'b1, 8'h38, 32'h0,        32'h0,        8'd10}, // R10 status after reset
    {1'b1, 8'h50, 32'h0,        32'h0,        8'd10}, // R10 second stage after reset
    {1'b1, 8'h44, 32'h0,        32'hFFFFFFFF, 8'd9},  // R9 unmapped read
    {1'b0, 8'h58, 32'hA5A5A5A5, 32'h0,        8'd1},
    {1'b1, 8'h58, 32'h0,        32'hA5A5A5A5, 8'd1},  // R1 polarity readback
    {1'b0, 8'h5C, 32'hFFFFFFFF, 32'h0,        8'd8},
    {1'b1, 8'h5C, 32'h0,        32'h0,        8'd8},  // R8 raw write ignored
    {1'b0, 8'h40, 32'h12345678, 32'h0,        8'd9},
    {1'b1, 8'h40, 32'h0,        32'h0,        8'd9},  // R9 error address reads 0
    {1'b0, 8'h44, 32'h0,        32'h0,        8'd9},
    {1'b1, 8'h44, 32'h0,        32'hFFFFFFFF, 8'd9},  // R9 unmapped write ignored
    {1'b0, 8'h34, 32'hFFFF8000, 32'h0,        8'd1},
    {1'b1, 8'h34, 32'h0,        32'hFFFF8000, 8'd1},  // R1 first mask readback
    {1'b0, 8'h54, 32'h00000800, 32'h0,        8'd1},
    {1'b1, 8'h54, 32'h0,        32'h00000800, 8'd1}   // R1 second mask readback
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    idle(3);
    rst = 1'b0;
    idle(1);
    chk("R10 irq_out", {31'b0, irq_out}, 32'h0);
    chk("R10 rdata", bus_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][80]) begin
        rd(VEC[i][79:72], rv);
        chk($sformatf("R%0d vector %0d", VEC[i][7:0], i), rv, VEC[i][39:8]);
      end else begin
        wr(VEC[i][79:72], VEC[i][71:40]);
      end
    end

    // R2 line 0 latched and sticky; R4 gated while enable is 0
    ser_irq[0] = 1'b1; idle(2); ser_irq[0] = 1'b0; idle(3);
    rd(8'h38, rv); chk("R2 line0 sticky", rv, 32'h80000000);
    rd(8'h5C, rv); chk("R4 no enable raw", rv, 32'h0);
    rd(8'h50, rv); chk("R4 no enable stage2", rv, 32'h0);
    chk("R4 no enable irq", {31'b0, irq_out}, 32'h0);

    // R5 R6 R7 enable propagates
    wr(8'h30, 32'h80000000); idle(3);
    rd(8'h30, rv); chk("R1 control readback", rv, 32'h80000000);
    rd(8'h5C, rv); chk("R5 raw set", rv, 32'h00000800);
    rd(8'h50, rv); chk("R6 stage2 latched", rv, 32'h00000800);
    chk("R7 irq high", {31'b0, irq_out}, 32'h1);
    wr(8'h58, 32'h0); idle(2);
    chk("R8 polarity no effect", {31'b0, irq_out}, 32'h1);

    // R3 first-stage clear; R5 raw falls; R6 stage2 stays
    wr(8'h38, 32'h80000000); idle(3);
    rd(8'h38, rv); chk("R3 stage1 cleared", rv, 32'h0);
    rd(8'h5C, rv); chk("R5 raw falls", rv, 32'h0);
    rd(8'h50, rv); chk("R6 stage2 sticky", rv, 32'h00000800);
    chk("R7 irq still high", {31'b0, irq_out}, 32'h1);

    // R3 second-stage clear; R7 output drops
    wr(8'h50, 32'h00000800); idle(3);
    rd(8'h50, rv); chk("R3 stage2 cleared", rv, 32'h0);
    chk("R7 irq low", {31'b0, irq_out}, 32'h0);

    // R11 clear while line 16 still high: set wins
    ser_irq[16] = 1'b1; idle(2);
    wr(8'h38, 32'h00008000); idle(1);
    rd(8'h38, rv); chk("R11 set beats clear", rv, 32'h00008000);
    ser_irq[16] = 1'b0;
    wr(8'h38, 32'hFFFFFFFF);
    wr(8'h50, 32'hFFFFFFFF); idle(3);
    rd(8'h50, rv); chk("R3 full clear", rv, 32'h0);

    // R6 second mask gates latching, then a mask write re-evaluates
    wr(8'h54, 32'h0);
    ser_irq[1] = 1'b1; idle(2); ser_irq[1] = 1'b0; idle(3);
    rd(8'h5C, rv); chk("R5 raw with line1", rv, 32'h00000800);
    rd(8'h50, rv); chk("R6 masked no latch", rv, 32'h0);
    chk("R7 masked irq low", {31'b0, irq_out}, 32'h0);
    wr(8'h54, 32'h00000800); idle(3);
    rd(8'h50, rv); chk("R6 latch after mask", rv, 32'h00000800);
    chk("R7 irq after mask", {31'b0, irq_out}, 32'h1);

    // R4 first mask gates the summary
    wr(8'h34, 32'h0); idle(2);
    rd(8'h5C, rv); chk("R4 mask gates raw", rv, 32'h0);
    wr(8'h30, 32'h0); wr(8'h34, 32'hFFFF8000); idle(2);
    rd(8'h5C, rv); chk("R4 enable gates raw", rv, 32'h0);

    // R2 error event 0 sets bit 2
    err_evt[0] = 1'b1; idle(1); err_evt[0] = 1'b0; idle(2);
    rd(8'h38, rv); chk("R2 error event bit", rv, 32'h40000004);

    // R10 reset mid-run
    rst = 1'b1; idle(2); rst = 1'b0; idle(1);
    chk("R10 irq after reset", {31'b0, irq_out}, 32'h0);
    rd(8'h38, rv); chk("R10 stage1 after reset", rv, 32'h0);
    rd(8'h50, rv); chk("R10 stage2 after reset", rv, 32'h0);
    rd(8'h54, rv); chk("R10 mask after reset", rv, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule